// File: doc/BRIEF.md
# Time-Base Counter Event Capture

This block records the value of a free-running time-base counter at the moment a compare event arrives. It keeps two holding registers. The working register takes the counter value when a qualified event occurs. The snapshot register takes a copy of the working register at a chosen reference point in each counter cycle. The reference point is either the counter reaching zero or the counter reaching its period.

A read-source bit selects what a processor read port sees. In snapshot mode the read port shows the copy taken at the last reference point, so the value stays steady for a whole counter cycle. In live mode the read port shows the working register directly, and the snapshot register is left untouched.

An enable bit gates capture. Only the first qualified event after each reference point is kept. Reset counts as a reference point for this purpose. The counter generator and any bus protocol sit outside the block.

Top module: `ctr_capture`

## Requirements
- R1: After reset both holding registers are 0 and rd_data reads 0. With both control inputs low, the block is in snapshot mode with capture disabled.
- R2: While cap_en is 0, dc_event has no effect on the working register. This holds even right after a reference point.
- R3: When cap_en is 1 and capture is armed, a dc_event pulse loads tb_count into the working register on that clock edge. In live mode the new value appears on rd_data after that edge.
- R4: Once a capture has been taken, further dc_event pulses are ignored until the next selected reference pulse re-arms capture. Capture is armed after reset.
- R5: The selected reference is ref_zero when ref_sel is 0 and ref_period when ref_sel is 1. A pulse on the other reference input neither re-arms capture nor triggers a copy.
- R6: In snapshot mode (live_mode = 0), each selected reference pulse copies the working register into the snapshot register, and rd_data shows the snapshot register.
- R7: In live mode (live_mode = 1), rd_data shows the working register, and the snapshot register keeps its value across reference pulses.
- R8: If a capture and a copy fall in the same cycle, the snapshot register receives the working value from before that capture.
- R9: A dc_event in the same cycle as the selected reference pulse is captured as the first event of the new cycle, and it consumes the re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | CNT_W | Current time-base counter value |
| dc_event | input | 1 | Compare event pulse |
| ref_zero | input | 1 | Counter-equals-zero pulse |
| ref_period | input | 1 | Counter-equals-period pulse |
| ref_sel | input | 1 | Reference select: 0 zero, 1 period |
| cap_en | input | 1 | Capture enable |
| live_mode | input | 1 | Read source: 0 snapshot, 1 working register |
| rd_data | output | CNT_W | Read data |

## Verification
A directed sequence walks through the cases one at a time. It places repeated events within a single counter cycle, which tells first-event capture apart from last-event capture. It pulses the unselected reference, which tells correct reference decoding apart from swapped or ORed decoding. It makes an event coincide with the selected reference, which separates old-value copying from new-value copying and shows whether the event consumes the re-arm. A sweep then covers every combination of the read source, the reference select and the enable, with an arithmetic model in the bench. Events, zero pulses and period pulses are taken from a pseudo-random sequence on a counter that counts up to a small period. This exposes ordering mistakes that the directed sequence does not reach.

// File: rtl/ctr_capture_pkg.sv
package ctr_capture_pkg;
    typedef enum logic {
        REF_AT_ZERO   = 1'b0,
        REF_AT_PERIOD = 1'b1
    } ref_kind_e;

    typedef enum logic {
        READ_SNAPSHOT = 1'b0,
        READ_LIVE     = 1'b1
    } read_src_e;
endpackage

// File: rtl/ctr_capture_ref_pick.sv
module ctr_capture_ref_pick
    import ctr_capture_pkg::*;
(
    input  logic ref_sel,
    input  logic ref_zero,
    input  logic ref_period,
    output logic ref_hit
);
    ref_kind_e kind;

    always_comb begin
        kind    = ref_kind_e'(ref_sel);
        ref_hit = (kind == REF_AT_PERIOD) ? ref_period : ref_zero;
    end
endmodule

// File: rtl/ctr_capture_arm.sv
module ctr_capture_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_hit,
    input  logic event_ok,
    output logic take,
    output logic armed
);
    typedef struct packed {
        logic armed;
    } arm_state_t;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = event_ok && (st_q.armed || ref_hit);
        if (take) begin
            st_d.armed = 1'b0;
        end else if (ref_hit) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/ctr_capture_store.sv
module ctr_capture_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             copy,
    input  logic [CNT_W-1:0] tb_count,
    output logic [CNT_W-1:0] active_val,
    output logic [CNT_W-1:0] shadow_val
);
    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] shadow;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (copy) begin
            st_d.shadow = st_q.active;
        end
        if (take) begin
            st_d.active = tb_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_val = st_q.active;
    assign shadow_val = st_q.shadow;
endmodule

// File: rtl/ctr_capture.sv
module ctr_capture
    import ctr_capture_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_count,
    input  logic             dc_event,
    input  logic             ref_zero,
    input  logic             ref_period,
    input  logic             ref_sel,
    input  logic             cap_en,
    input  logic             live_mode,
    output logic [CNT_W-1:0] rd_data
);
    logic             ref_hit;
    logic             take;
    logic             armed;
    logic             copy;
    logic [CNT_W-1:0] active_val;
    logic [CNT_W-1:0] shadow_val;
    read_src_e        src;

    ctr_capture_ref_pick u_ref (
        .ref_sel    (ref_sel),
        .ref_zero   (ref_zero),
        .ref_period (ref_period),
        .ref_hit    (ref_hit)
    );

    ctr_capture_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_hit  (ref_hit),
        .event_ok (cap_en && dc_event),
        .take     (take),
        .armed    (armed)
    );

    always_comb begin
        src  = read_src_e'(live_mode);
        copy = ref_hit && (src == READ_SNAPSHOT);
    end

    ctr_capture_store #(.CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .copy       (copy),
        .tb_count   (tb_count),
        .active_val (active_val),
        .shadow_val (shadow_val)
    );

    always_comb begin
        rd_data = (src == READ_LIVE) ? active_val : shadow_val;
    end
endmodule

// File: rtl/ctr_capture_chk.sv
module ctr_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tb_count,
    input logic             dc_event,
    input logic             ref_zero,
    input logic             ref_period,
    input logic             ref_sel,
    input logic             cap_en,
    input logic             live_mode,
    input logic [CNT_W-1:0] active_val,
    input logic [CNT_W-1:0] shadow_val,
    input logic             armed
);
    logic sel_pulse;
    assign sel_pulse = ref_sel ? ref_period : ref_zero;

    // R2: a disabled capture leaves the working register alone
    p_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(active_val));

    // R3: a qualified event loads the counter value
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && dc_event && (armed || sel_pulse)) |=> active_val == $past(tb_count));

    // R4: once disarmed and with no reference, the working register holds
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !sel_pulse) |=> $stable(active_val));

    // R6 and R8: a copy takes the pre-capture working value
    p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pulse && !live_mode) |=> shadow_val == $past(active_val));

    // R7: no copy in live mode or without a reference
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_pulse || live_mode) |=> $stable(shadow_val));

    // R9: a capture on a reference cycle leaves capture disarmed
    p_ref_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && dc_event && sel_pulse) |=> !armed);
endmodule

bind ctr_capture ctr_capture_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_count   (tb_count),
    .dc_event   (dc_event),
    .ref_zero   (ref_zero),
    .ref_period (ref_period),
    .ref_sel    (ref_sel),
    .cap_en     (cap_en),
    .live_mode  (live_mode),
    .active_val (active_val),
    .shadow_val (shadow_val),
    .armed      (armed)
);

// File: tb/test_ctr_capture.sv
`timescale 1ns/1ps
module test_ctr_capture;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tb_count = '0;
    logic         dc_event = 1'b0;
    logic         ref_zero = 1'b0;
    logic         ref_period = 1'b0;
    logic         ref_sel = 1'b0;
    logic         cap_en = 1'b0;
    logic         live_mode = 1'b0;
    logic [W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [W-1:0] m_act = '0;
    logic [W-1:0] m_shd = '0;
    bit           m_arm = 1'b1;

    always #10 clk = ~clk;

    ctr_capture #(.CNT_W(W)) i_ctr_capture (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .dc_event(dc_event),
        .ref_zero(ref_zero), .ref_period(ref_period), .ref_sel(ref_sel),
        .cap_en(cap_en), .live_mode(live_mode), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data=%0d expected=%0d at %0t", req, rd_data, exp, $time);
        end
    endtask

    // drive at negedge, advance one edge, update model, return at negedge
    task automatic step(input logic [W-1:0] cnt, input bit ev, input bit z, input bit p);
        bit hit;
        bit cap;
        tb_count = cnt; dc_event = ev; ref_zero = z; ref_period = p;
        @(posedge clk);
        hit = ref_sel ? p : z;
        cap = cap_en && ev && (m_arm || hit);
        if (hit && !live_mode) m_shd = m_act;
        if (cap) m_act = cnt;
        m_arm = cap ? 1'b0 : (hit ? 1'b1 : m_arm);
        @(negedge clk);
        dc_event = 1'b0; ref_zero = 1'b0; ref_period = 1'b0;
    endtask

    function automatic logic [W-1:0] m_read();
        return live_mode ? m_act : m_shd;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", 16'd0);

        // active mode, capture disabled
        live_mode = 1'b1;
        step(16'd5, 1, 0, 0);
        check("R2", 16'd0);
        step(16'd6, 1, 1, 0);
        check("R2", 16'd0);
        // armed after reset, zero ref at 6 re-armed anyway
        cap_en = 1'b1;
        step(16'd9, 1, 0, 0);
        check("R3", 16'd9);
        step(16'd11, 1, 0, 0);
        check("R4", 16'd9);
        step(16'd0, 0, 1, 0);
        step(16'd13, 1, 0, 0);
        check("R4", 16'd13);
        // unselected period pulse must not re-arm
        step(16'd7, 0, 0, 1);
        step(16'd20, 1, 0, 0);
        check("R5", 16'd13);
        ref_sel = 1'b1;
        step(16'd0, 0, 1, 0);
        step(16'd21, 1, 0, 0);
        check("R5", 16'd13);
        step(16'd7, 0, 0, 1);
        step(16'd22, 1, 0, 0);
        check("R5", 16'd22);
        // snapshot never copied during live mode
        live_mode = 1'b0;
        #1;
        check("R7", 16'd0);
        step(16'd7, 0, 0, 1);
        check("R6", 16'd22);
        step(16'd30, 1, 0, 0);
        check("R6", 16'd22);
        step(16'd40, 1, 0, 1);
        check("R8", 16'd30);
        live_mode = 1'b1;
        #1;
        check("R9", 16'd40);
        step(16'd41, 1, 0, 0);
        check("R9", 16'd40);
        step(16'd7, 0, 0, 1);
        live_mode = 1'b0;
        #1;
        check("R7", 16'd30);

        // sweep: reset, then every mode combination
        lcg = 32'h1234_5678;
        for (int cfg = 0; cfg < 8; cfg++) begin
            rst_n = 1'b0;
            step(16'd0, 0, 0, 0);
            rst_n = 1'b1;
            m_act = '0; m_shd = '0; m_arm = 1'b1;
            live_mode = cfg[0];
            ref_sel   = cfg[1];
            cap_en    = cfg[2];
            #1;
            check("R1", 16'd0);
            for (int c = 0; c < 400; c++) begin
                logic [W-1:0] cnt;
                bit ev;
                cnt = W'(c % 8);
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                ev = lcg[20] & lcg[23];
                step(cnt + W'(c * 8 & 16'hff00), ev, cnt == 0, cnt == 7);
                if (!cap_en)       check("R2", m_read());
                else if (live_mode) check("R3", m_read());
                else               check("R6", m_read());
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule